// File: doc/BRIEF.md
# Store-to-Load Forwarding Buffer

This block holds stores that have executed but are still speculative. They may not update the data cache yet. Each store enters with its address and data and waits in arrival order. A commit pulse from the retirement logic releases the oldest entry to the memory write port, one per cycle.

Every load is looked up in the buffer in the same cycle that the data cache is read. The lookup compares only a low slice of the address. This keeps the comparators narrow. When an older buffered store hits on that slice, its data is returned in place of the cache word. When several stores hit, the youngest store that is still older than the load wins.

A second path compares the full address of the chosen store. It flags the load for replay when the narrow match was an alias. This covers two cases: a plain false forward, and a younger alias that hid a genuine full match. Load age is given by a boundary pointer. It is the value of the buffer's tail pointer that the load captured when it was dispatched.

Top module: `stfwd_buffer`

## Requirements
- R1: After reset the buffer is empty. `st_ready` is 1, `rsp_valid` is 0, `mem_wr_valid` is 0 and `sq_tail` is 0.
- R2: A store is taken when `st_valid` and `st_ready` are both 1. `st_ready` is 0 while DEPTH entries are held. A store offered while the buffer is full is dropped and never reaches memory.
- R3: When `commit` is 1 and the buffer is not empty, `mem_wr_valid` is 1 in that same cycle, carrying the oldest entry's address and data, and that entry is removed at the clock edge. Entries leave in arrival order. When `commit` is 1 on an empty buffer, `mem_wr_valid` stays 0. A removed store no longer forwards.
- R4: Every load presented with `ld_valid` gets a response one clock later (`rsp_valid`=1). If no older store matches, `rsp_data` equals the `cache_data` sampled with the load, and both `rsp_fwd` and `rsp_replay` are 0.
- R5: The narrow compare uses address bits [MATCH_W-1:0]. If one or more older stores match on those bits, `rsp_fwd`=1 and `rsp_data` is the data of the youngest such store.
- R6: A store counts as older only if its position lies between the oldest held entry and `ld_bound` (exclusive). Stores at or beyond `ld_bound` are ignored by the lookup.
- R7: `rsp_replay`=1 when the selected store's full address differs from `ld_addr`. `rsp_replay` is never 1 without `rsp_fwd`.
- R8: `rsp_replay`=1 when a younger narrow-only alias hides an older store whose full address equals `ld_addr`. The alias's data is what is returned.
- R9: `sq_tail` is a pointer with one wrap bit. Its width is log2(DEPTH)+1. It advances by one, modulo 2*DEPTH, on each accepted store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store entry offered |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Room for a store |
| sq_tail | output | log2(DEPTH)+1 | Allocation pointer, captured by loads as their age |
| commit | input | 1 | Release the oldest store |
| mem_wr_valid | output | 1 | Store being written to memory this cycle |
| mem_wr_addr | output | ADDR_W | Address of the released store |
| mem_wr_data | output | DATA_W | Data of the released store |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load address |
| ld_bound | input | log2(DEPTH)+1 | Tail pointer seen by the load at dispatch |
| cache_data | input | DATA_W | Word read from the cache in parallel |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DATA_W | Forwarded or cache data |
| rsp_fwd | output | 1 | Data came from the buffer |
| rsp_replay | output | 1 | Forwarding decision wrong, re-execute the load |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=16, DATA_W=16 and MATCH_W=8. With only four entries, the full-buffer stall and the pointer wrap are reached in a handful of stores. The 8-bit match slice lets addresses such as 0x1010 and 0x3010 alias on purpose. That alias sets up false forwards and hidden full matches beside true ones. Boundary pointers of 1, 2 and 3 in a full buffer show that stores younger than the load are excluded.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;
   typedef enum logic [1:0] {
      LK_MISS   = 2'd0,
      LK_CLEAN  = 2'd1,
      LK_ALIAS  = 2'd2
   } lookup_kind_e;
endpackage

// File: rtl/sfb_store_queue.sv
module sfb_store_queue #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [ADDR_W-1:0]              push_addr,
   input  logic [DATA_W-1:0]              push_data,
   input  logic                           pop,
   output logic [DEPTH-1:0][ADDR_W-1:0]   addr_arr,
   output logic [DEPTH-1:0][DATA_W-1:0]   data_arr,
   output logic [PTR_W:0]                 head_ptr,
   output logic [PTR_W:0]                 tail_ptr,
   output logic [PTR_W:0]                 occ,
   output logic                           full,
   output logic                           empty
);
   logic [PTR_W:0] head_q, tail_q;

   assign occ      = tail_q - head_q;
   assign full     = (occ == (PTR_W+1)'(DEPTH));
   assign empty    = (occ == '0);
   assign head_ptr = head_q;
   assign tail_ptr = tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (push && !full) tail_q <= tail_q + 1'b1;
         if (pop && !empty) head_q <= head_q + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr_arr[g] <= '0;
               data_arr[g] <= '0;
            end else if (push && !full && tail_q[PTR_W-1:0] == PTR_W'(g)) begin
               addr_arr[g] <= push_addr;
               data_arr[g] <= push_data;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sfb_part_match.sv
module sfb_part_match #(
   parameter int DEPTH   = 4,
   parameter int ADDR_W  = 16,
   parameter int MATCH_W = 8,
   localparam int PTR_W  = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0][ADDR_W-1:0] addr_arr,
   input  logic [PTR_W:0]               head_ptr,
   input  logic [PTR_W:0]               occ,
   input  logic [ADDR_W-1:0]            ld_addr,
   input  logic [PTR_W:0]               ld_bound,
   output logic                         hit,
   output logic [PTR_W-1:0]             sel
);
   logic [PTR_W:0]   older_cnt;
   logic [PTR_W-1:0] slot;

   assign older_cnt = ld_bound - head_ptr;

   // Walk from oldest to youngest; the last match seen is the youngest older store.
   always_comb begin
      hit  = 1'b0;
      sel  = '0;
      slot = '0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = head_ptr[PTR_W-1:0] + PTR_W'(k);
         if ((PTR_W+1)'(k) < occ && (PTR_W+1)'(k) < older_cnt &&
             addr_arr[slot][MATCH_W-1:0] == ld_addr[MATCH_W-1:0]) begin
            hit = 1'b1;
            sel = slot;
         end
      end
   end
endmodule

// File: rtl/sfb_order_check.sv
module sfb_order_check #(
   parameter int DEPTH   = 4,
   parameter int ADDR_W  = 16,
   parameter int MATCH_W = 8,
   localparam int PTR_W  = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0][ADDR_W-1:0] addr_arr,
   input  logic                         hit,
   input  logic [PTR_W-1:0]             sel,
   input  logic [ADDR_W-1:0]            ld_addr,
   output logic                         alias_bad
);
   generate
      if (MATCH_W < ADDR_W) begin : g_full_cmp
         assign alias_bad = hit && (addr_arr[sel] != ld_addr);
      end else begin : g_no_alias
         assign alias_bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/stfwd_buffer.sv
module stfwd_buffer #(
   parameter int DEPTH   = 4,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int MATCH_W = 8,
   localparam int PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   output logic              st_ready,
   output logic [PTR_W:0]    sq_tail,
   input  logic              commit,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [PTR_W:0]    ld_bound,
   input  logic [DATA_W-1:0] cache_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_fwd,
   output logic              rsp_replay
);
   import stfwd_pkg::*;

   initial begin
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH)
         $error("stfwd_buffer: DEPTH must be a power of two, at least 2");
      if (MATCH_W < 1 || MATCH_W > ADDR_W)
         $error("stfwd_buffer: MATCH_W must lie in 1..ADDR_W");
      if (DATA_W < 1)
         $error("stfwd_buffer: DATA_W must be positive");
   end

   logic [DEPTH-1:0][ADDR_W-1:0] addr_arr;
   logic [DEPTH-1:0][DATA_W-1:0] data_arr;
   logic [PTR_W:0]               head_ptr, occ;
   logic                         full, empty;
   logic                         hit, alias_bad;
   logic [PTR_W-1:0]             sel;
   lookup_kind_e                 kind;

   sfb_store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(st_valid), .push_addr(st_addr), .push_data(st_data),
      .pop(commit),
      .addr_arr(addr_arr), .data_arr(data_arr),
      .head_ptr(head_ptr), .tail_ptr(sq_tail), .occ(occ),
      .full(full), .empty(empty)
   );

   sfb_part_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .MATCH_W(MATCH_W)) u_match (
      .addr_arr(addr_arr), .head_ptr(head_ptr), .occ(occ),
      .ld_addr(ld_addr), .ld_bound(ld_bound),
      .hit(hit), .sel(sel)
   );

   sfb_order_check #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .MATCH_W(MATCH_W)) u_order (
      .addr_arr(addr_arr), .hit(hit), .sel(sel), .ld_addr(ld_addr),
      .alias_bad(alias_bad)
   );

   assign st_ready     = !full;
   assign mem_wr_valid = commit && !empty;
   assign mem_wr_addr  = addr_arr[head_ptr[PTR_W-1:0]];
   assign mem_wr_data  = data_arr[head_ptr[PTR_W-1:0]];

   always_comb begin
      if (!hit)          kind = LK_MISS;
      else if (alias_bad) kind = LK_ALIAS;
      else               kind = LK_CLEAN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
         rsp_fwd    <= 1'b0;
         rsp_replay <= 1'b0;
      end else begin
         rsp_valid  <= ld_valid;
         rsp_fwd    <= ld_valid && (kind != LK_MISS);
         rsp_replay <= ld_valid && (kind == LK_ALIAS);
         rsp_data   <= (kind == LK_MISS) ? cache_data : data_arr[sel];
      end
   end
endmodule

// File: rtl/stfwd_buffer_chk.sv
module stfwd_buffer_chk #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_valid,
   input logic              st_ready,
   input logic [PTR_W:0]    sq_tail,
   input logic              commit,
   input logic              mem_wr_valid,
   input logic              ld_valid,
   input logic [DATA_W-1:0] cache_data,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_fwd,
   input logic              rsp_replay
);
   AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      !st_ready |=> sq_tail == $past(sq_tail)); // R2
   AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready) |=> sq_tail == $past(sq_tail) + 1'b1); // R9
   AST_WRITE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> commit); // R3
   AST_RSP_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> rsp_valid); // R4
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> !rsp_valid); // R4
   AST_MISS_USES_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> (rsp_fwd || rsp_data == $past(cache_data))); // R4
   AST_REPLAY_ONLY_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_replay |-> rsp_fwd); // R7
endmodule

bind stfwd_buffer stfwd_buffer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
   .sq_tail(sq_tail), .commit(commit), .mem_wr_valid(mem_wr_valid),
   .ld_valid(ld_valid), .cache_data(cache_data), .rsp_valid(rsp_valid),
   .rsp_data(rsp_data), .rsp_fwd(rsp_fwd), .rsp_replay(rsp_replay)
);

// File: tb/sim_stfwd_buffer.sv
module sim_stfwd_buffer;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4, ADDR_W = 16, DATA_W = 16, MATCH_W = 8;
   localparam int PTR_W = $clog2(DEPTH);

   logic clk = 1'b0, rst_n = 1'b0;
   logic st_valid = 1'b0, commit = 1'b0, ld_valid = 1'b0;
   logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0;
   logic [DATA_W-1:0] st_data = '0, cache_data = '0;
   logic [PTR_W:0]    ld_bound = '0;
   logic st_ready, mem_wr_valid, rsp_valid, rsp_fwd, rsp_replay;
   logic [PTR_W:0]    sq_tail;
   logic [ADDR_W-1:0] mem_wr_addr;
   logic [DATA_W-1:0] mem_wr_data, rsp_data;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stfwd_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_W(MATCH_W)) u0 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
      .st_ready(st_ready), .sq_tail(sq_tail), .commit(commit),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_bound(ld_bound), .cache_data(cache_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fwd(rsp_fwd), .rsp_replay(rsp_replay)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_data = d;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   // Commit one store; mem write port checked in the same cycle as the pulse.
   task automatic do_commit(input string req, input logic vld, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d);
      @(negedge clk);
      commit = 1'b1;
      #1;
      check(req, "mem_wr_valid", 32'(mem_wr_valid), 32'(vld));
      if (vld) begin
         check(req, "mem_wr_addr", 32'(mem_wr_addr), 32'(a));
         check(req, "mem_wr_data", 32'(mem_wr_data), 32'(d));
      end
      @(negedge clk);
      commit = 1'b0;
   endtask

   // Issue one load, response sampled at the following negedge.
   task automatic load(input string req, input logic [ADDR_W-1:0] a, input logic [PTR_W:0] b,
                       input logic [DATA_W-1:0] exp_d, input logic exp_f, input logic exp_r);
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = a; ld_bound = b; cache_data = 16'hCAFE;
      @(negedge clk);
      ld_valid = 1'b0; cache_data = 16'h0BAD;
      check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
      check(req, "rsp_data", 32'(rsp_data), 32'(exp_d));
      check(req, "rsp_fwd", 32'(rsp_fwd), 32'(exp_f));
      check(req, "rsp_replay", 32'(rsp_replay), 32'(exp_r));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "st_ready", 32'(st_ready), 32'd1);
      check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
      check("R1", "mem_wr_valid", 32'(mem_wr_valid), 32'd0);
      check("R1", "sq_tail", 32'(sq_tail), 32'd0);
      do_commit("R3", 1'b0, '0, '0); // commit on empty buffer
   endtask

   task automatic t_fill();
      push(16'h1010, 16'h00A0);
      check("R9", "sq_tail after 1", 32'(sq_tail), 32'd1);
      push(16'h2020, 16'h00A1);
      push(16'h3010, 16'h00A2);
      check("R2", "st_ready with 3", 32'(st_ready), 32'd1);
      push(16'h4040, 16'h00A3);
      check("R2", "st_ready when full", 32'(st_ready), 32'd0);
      check("R9", "sq_tail after 4", 32'(sq_tail), 32'd4);
      push(16'h5555, 16'h00FF); // dropped while full
      check("R2", "sq_tail unchanged", 32'(sq_tail), 32'd4);
   endtask

   task automatic t_lookups();
      load("R4", 16'h7077, 3'd4, 16'hCAFE, 1'b0, 1'b0);
      load("R5", 16'h2020, 3'd4, 16'h00A1, 1'b1, 1'b0);
      load("R5", 16'h3010, 3'd4, 16'h00A2, 1'b1, 1'b0); // youngest of two slice hits
      load("R7", 16'h5010, 3'd4, 16'h00A2, 1'b1, 1'b1); // false forward
      load("R8", 16'h1010, 3'd4, 16'h00A2, 1'b1, 1'b1); // full match hidden by younger alias
      load("R6", 16'h1010, 3'd1, 16'h00A0, 1'b1, 1'b0);
      load("R6", 16'h3010, 3'd2, 16'h00A0, 1'b1, 1'b1); // entry 2 excluded
      load("R6", 16'h4040, 3'd3, 16'hCAFE, 1'b0, 1'b0); // entry 3 excluded
   endtask

   task automatic t_drain();
      do_commit("R3", 1'b1, 16'h1010, 16'h00A0);
      check("R2", "st_ready after pop", 32'(st_ready), 32'd1);
      do_commit("R3", 1'b1, 16'h2020, 16'h00A1);
      do_commit("R3", 1'b1, 16'h3010, 16'h00A2);
      do_commit("R3", 1'b1, 16'h4040, 16'h00A3);
      do_commit("R2", 1'b0, '0, '0); // dropped store never released
   endtask

   task automatic t_wrap();
      push(16'h0101, 16'h00B0);
      check("R9", "sq_tail after wrap push", 32'(sq_tail), 32'd5);
      load("R9", 16'h0101, 3'd5, 16'h00B0, 1'b1, 1'b0);
      load("R3", 16'h1010, 3'd5, 16'hCAFE, 1'b0, 1'b0); // released store gone
      do_commit("R3", 1'b1, 16'h0101, 16'h00B0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_lookups();
      t_drain();
      t_wrap();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule